// File: doc/BRIEF.md
# Split-Transaction Retry and Timeout Engine

This block watches over one outgoing request on a serial bus link. It uses a single 32-bit limit word. That word sets how long a split transaction may wait for its response, how many isochronous cycles separate a busy acknowledge from the retransmission, how many retransmissions are allowed, and how long a command-block fetch is held back before its read request goes out. Every timer in the block advances only on the cycle-tick strobe, which arrives once per 125 µs isochronous cycle.

The link layer pulses `xact_start` when it queues a request, `tx_done` when the packet has left, `ack_valid` with an acknowledge code, and `rsp_rcvd` when the matching response packet arrives. The engine answers with a one-cycle `retx_req` when the packet must be sent again, `xact_ok` or `xact_fail` (with a cause on `fail_code`) when the transaction ends, and `fetch_go` when a delayed fetch may proceed. A bus reset stops any pending activity without producing a pulse, and it leaves the limit word as it was.

Top module: `srte_engine`

## Requirements
- R1: The limit word resets to 0x032008E0 and is loaded from `cfg_wdata` on a cycle with `cfg_we` high. `cfg_rdata` shows it. Its layout is: bits 31:16 split timeout, bits 15:8 retry interval, bits 7:4 retry limit, bits 3:0 fetch delay. Out of reset, all pulse outputs and `fail_code` are 0.
- R2: `bus_reset` leaves the limit word unchanged. It returns the transaction and the fetch timer to idle, and no `retx_req`, `xact_ok`, `xact_fail` or `fetch_go` pulse follows from the aborted activity.
- R3: An acknowledge code of 0x1 (complete) ends the transaction with an `xact_ok` pulse. A code of 0x2 (pending) keeps it waiting, and a later `rsp_rcvd` ends it with `xact_ok`.
- R4: The split timer is cleared and started by `tx_done` and counts cycle ticks. On the tick that takes its count above the split timeout, the engine pulses `xact_fail` with `fail_code` = 1. Exactly split-timeout ticks alone do not fail the transaction.
- R5: An acknowledge code of 0x4, 0x5 or 0x6 (busy) with retries remaining causes `retx_req` only after retry-interval cycle ticks. The pulse comes on the second clock after the last of those ticks, or on the second clock after the acknowledge when the interval is 0.
- R6: With a retry limit of 0, a busy acknowledge gives `xact_fail` with `fail_code` = 2 and no `retx_req`.
- R7: With a retry limit of n, at most n `retx_req` pulses are issued for one transaction. A busy acknowledge after the n-th retransmission gives `xact_fail` with `fail_code` = 2. Any non-busy acknowledge before that ends the retries.
- R8: Any acknowledge code other than 0x1, 0x2, 0x4, 0x5 or 0x6 gives `xact_fail` with `fail_code` = 3.
- R9: After `fetch_req`, `fetch_go` pulses once, only after fetch-delay cycle ticks. With a delay of 0 it pulses on the second clock after the request.
- R10: `xact_start` is ignored while a transaction is active. The split timeout, retry interval and retry limit are captured at `xact_start`, and later writes to the limit word do not change the active transaction.
- R11: `xact_ok` and `xact_fail` are single-cycle pulses and never high together. `fail_code` holds the cause of the most recent failure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_reset | input | 1 | Bus reset: aborts activity, keeps the limit word |
| cfg_we | input | 1 | Limit word write enable |
| cfg_wdata | input | 32 | Limit word write data |
| cfg_rdata | output | 32 | Current limit word |
| cyc_tick | input | 1 | One-cycle strobe per isochronous cycle |
| xact_start | input | 1 | A request has been queued |
| tx_done | input | 1 | The request packet has been transmitted |
| ack_valid | input | 1 | Acknowledge code is valid |
| ack_code | input | 4 | Acknowledge code |
| rsp_rcvd | input | 1 | Response packet received |
| fetch_req | input | 1 | Request a delayed command-block fetch |
| retx_req | output | 1 | Pulse: retransmit the packet |
| fetch_go | output | 1 | Pulse: issue the fetch read request |
| xact_ok | output | 1 | Pulse: transaction completed |
| xact_fail | output | 1 | Pulse: transaction failed |
| fail_code | output | 2 | Failure cause: 1 timeout, 2 busy exhausted, 3 acknowledge error |

## Verification
A wrong retry counter shows as one `retx_req` too many or too few, or as a busy-exhausted failure that comes one acknowledge early or late. Each of these is visible within a few clocks of the busy acknowledge that exposes it. An off-by-one in the tick counters moves `xact_fail`, `retx_req` or `fetch_go` by one cycle tick. The bench checks the outputs both after one tick fewer than the programmed value and after the exact value, so such a shift shows up within the three idle clocks that follow. Stale captured fields, or a bus reset that does not clear state, show as a pulse that should not appear after the stimulus in question.

// File: rtl/srte_pkg.sv
`timescale 1ns/1ps
package srte_pkg;
  localparam int ACK_W = 4;

  localparam logic [ACK_W-1:0] ACK_COMPLETE = 4'h1;
  localparam logic [ACK_W-1:0] ACK_PENDING  = 4'h2;

  typedef enum logic [1:0] {
    FC_NONE    = 2'd0,
    FC_TIMEOUT = 2'd1,
    FC_BUSY    = 2'd2,
    FC_ACKERR  = 2'd3
  } fail_e;

  typedef enum logic [1:0] {
    XS_IDLE    = 2'd0,
    XS_AWAIT   = 2'd1,
    XS_BACKOFF = 2'd2
  } xstate_e;

  // busy family: 0x4, 0x5, 0x6
  function automatic logic ack_is_busy(input logic [ACK_W-1:0] code);
    return (code == 4'h4) || (code == 4'h5) || (code == 4'h6);
  endfunction

  // strict greater-than comparison used by the split timer
  function automatic logic over_limit(input logic [31:0] count, input logic [31:0] limit);
    return count > limit;
  endfunction

  // a wait counter has covered its programmed ticks
  function automatic logic wait_done(input logic [31:0] count, input logic [31:0] target);
    return count >= target;
  endfunction
endpackage

// File: rtl/srte_cfg_reg.sv
`timescale 1ns/1ps
module srte_cfg_reg #(
  parameter int          W     = 32,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bus_reset,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] word_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     word_q <= RST_VAL;
    else if (wr_en) word_q <= wr_data;
  end

  AST_CFG_BUSRESET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_reset && !wr_en) |=> (word_q == $past(word_q))); // R2
endmodule

// File: rtl/srte_fetch_delay.sv
`timescale 1ns/1ps
module srte_fetch_delay #(
  parameter int FD_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_reset,
  input  logic            cyc_tick,
  input  logic            fetch_req,
  input  logic [FD_W-1:0] delay,
  output logic            fetch_go
);
  import srte_pkg::*;

  logic            waiting;
  logic [FD_W-1:0] cnt;
  logic [FD_W-1:0] dly_q;
  logic            ev_fire;

  assign ev_fire = waiting && wait_done(32'(cnt), 32'(dly_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      waiting  <= 1'b0;
      cnt      <= '0;
      dly_q    <= '0;
      fetch_go <= 1'b0;
    end else begin
      fetch_go <= 1'b0;
      if (bus_reset) begin
        waiting <= 1'b0;
      end else if (!waiting) begin
        if (fetch_req) begin
          waiting <= 1'b1;
          cnt     <= '0;
          dly_q   <= delay;
        end
      end else if (ev_fire) begin
        fetch_go <= 1'b1;
        waiting  <= 1'b0;
      end else if (cyc_tick) begin
        cnt <= cnt + FD_W'(1);
      end
    end
  end

  AST_FETCH_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    waiting |-> (cnt <= dly_q)); // R9
  AST_FETCH_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_go |=> !fetch_go); // R9
endmodule

// File: rtl/srte_xact_fsm.sv
`timescale 1ns/1ps
module srte_xact_fsm #(
  parameter int SPLIT_W = 16,
  parameter int IVL_W   = 8,
  parameter int LIM_W   = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        bus_reset,
  input  logic                        cyc_tick,
  input  logic                        xact_start,
  input  logic                        tx_done,
  input  logic                        ack_valid,
  input  logic [srte_pkg::ACK_W-1:0]  ack_code,
  input  logic                        rsp_rcvd,
  input  logic [SPLIT_W-1:0]          split_to,
  input  logic [IVL_W-1:0]            retry_ivl,
  input  logic [LIM_W-1:0]            retry_lim,
  output logic                        retx_req,
  output logic                        xact_ok,
  output logic                        xact_fail,
  output logic [1:0]                  fail_code
);
  import srte_pkg::*;

  localparam int CW = (SPLIT_W + 1 > IVL_W) ? SPLIT_W + 1 : IVL_W;

  xstate_e            state;
  logic               run;
  logic [CW-1:0]      cnt;
  logic [CW-1:0]      cnt_inc;
  logic [LIM_W-1:0]   tries;
  logic [SPLIT_W-1:0] to_q;
  logic [IVL_W-1:0]   ivl_q;
  logic [LIM_W-1:0]   lim_q;
  fail_e              fc_q;

  // named internal events
  logic in_await, ev_rsp, ev_ack, ev_busy, ev_exhaust, ev_timeout, ev_retx;

  assign cnt_inc    = cnt + CW'(1);
  assign in_await   = (state == XS_AWAIT);
  assign ev_rsp     = in_await && rsp_rcvd;
  assign ev_ack     = in_await && !rsp_rcvd && ack_valid;
  assign ev_busy    = ev_ack && ack_is_busy(ack_code);
  assign ev_exhaust = ev_busy && (tries == lim_q);
  assign ev_timeout = in_await && !rsp_rcvd && !ack_valid && !tx_done && run && cyc_tick &&
                      over_limit(32'(cnt_inc), 32'(to_q));
  assign ev_retx    = (state == XS_BACKOFF) && wait_done(32'(cnt), 32'(ivl_q));
  assign fail_code  = fc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= XS_IDLE;
      run       <= 1'b0;
      cnt       <= '0;
      tries     <= '0;
      to_q      <= '0;
      ivl_q     <= '0;
      lim_q     <= '0;
      fc_q      <= FC_NONE;
      retx_req  <= 1'b0;
      xact_ok   <= 1'b0;
      xact_fail <= 1'b0;
    end else begin
      retx_req  <= 1'b0;
      xact_ok   <= 1'b0;
      xact_fail <= 1'b0;
      if (bus_reset) begin
        state <= XS_IDLE;
        run   <= 1'b0;
      end else begin
        unique case (state)
          XS_IDLE: begin
            if (xact_start) begin
              state <= XS_AWAIT;
              to_q  <= split_to;
              ivl_q <= retry_ivl;
              lim_q <= retry_lim;
              tries <= '0;
              run   <= 1'b0;
              cnt   <= '0;
            end
          end
          XS_AWAIT: begin
            if (ev_rsp) begin
              xact_ok <= 1'b1;
              state   <= XS_IDLE;
            end else if (ev_ack) begin
              if (ack_code == ACK_COMPLETE) begin
                xact_ok <= 1'b1;
                state   <= XS_IDLE;
              end else if (ack_code == ACK_PENDING) begin
                state <= XS_AWAIT;
              end else if (ev_busy) begin
                if (ev_exhaust) begin
                  xact_fail <= 1'b1;
                  fc_q      <= FC_BUSY;
                  state     <= XS_IDLE;
                end else begin
                  state <= XS_BACKOFF;
                  run   <= 1'b0;
                  cnt   <= '0;
                end
              end else begin
                xact_fail <= 1'b1;
                fc_q      <= FC_ACKERR;
                state     <= XS_IDLE;
              end
            end else if (tx_done) begin
              run <= 1'b1;
              cnt <= '0;
            end else if (ev_timeout) begin
              xact_fail <= 1'b1;
              fc_q      <= FC_TIMEOUT;
              state     <= XS_IDLE;
              run       <= 1'b0;
            end else if (run && cyc_tick) begin
              cnt <= cnt_inc;
            end
          end
          XS_BACKOFF: begin
            if (ev_retx) begin
              retx_req <= 1'b1;
              tries    <= tries + LIM_W'(1);
              state    <= XS_AWAIT;
              run      <= 1'b0;
              cnt      <= '0;
            end else if (cyc_tick) begin
              cnt <= cnt_inc;
            end
          end
          default: state <= XS_IDLE;
        endcase
      end
    end
  end

  AST_RETX_UNDER_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    ev_retx |-> (tries < lim_q)); // R7
  AST_NO_RETX_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ev_retx |-> (lim_q != '0)); // R6
  AST_RETX_FROM_BACKOFF: assert property (@(posedge clk) disable iff (!rst_n)
    retx_req |-> ($past(state) == XS_BACKOFF)); // R5
  AST_TIMEOUT_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (xact_fail && fail_code == 2'd1) |-> $past(cyc_tick)); // R4
  AST_OK_FAIL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(xact_ok && xact_fail)); // R11
  AST_FAIL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    xact_fail |=> !xact_fail); // R11
  AST_FAIL_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    xact_fail |-> (fail_code != 2'd0)); // R11
endmodule

// File: rtl/srte_engine.sv
`timescale 1ns/1ps
module srte_engine #(
  parameter int SPLIT_W = 16,
  parameter int IVL_W   = 8,
  parameter int LIM_W   = 4,
  parameter int FD_W    = 4,
  parameter logic [SPLIT_W+IVL_W+LIM_W+FD_W-1:0] CFG_RESET = 32'h0320_08E0
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  bus_reset,
  input  logic                                  cfg_we,
  input  logic [SPLIT_W+IVL_W+LIM_W+FD_W-1:0]   cfg_wdata,
  output logic [SPLIT_W+IVL_W+LIM_W+FD_W-1:0]   cfg_rdata,
  input  logic                                  cyc_tick,
  input  logic                                  xact_start,
  input  logic                                  tx_done,
  input  logic                                  ack_valid,
  input  logic [3:0]                            ack_code,
  input  logic                                  rsp_rcvd,
  input  logic                                  fetch_req,
  output logic                                  retx_req,
  output logic                                  fetch_go,
  output logic                                  xact_ok,
  output logic                                  xact_fail,
  output logic [1:0]                            fail_code
);
  localparam int CFG_W  = SPLIT_W + IVL_W + LIM_W + FD_W;
  localparam int FD_LO  = 0;
  localparam int LIM_LO = FD_LO + FD_W;
  localparam int IVL_LO = LIM_LO + LIM_W;
  localparam int TO_LO  = IVL_LO + IVL_W;

  logic [CFG_W-1:0] word_q;

  srte_cfg_reg #(.W(CFG_W), .RST_VAL(CFG_RESET)) u_cfg (
    .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset),
    .wr_en(cfg_we), .wr_data(cfg_wdata), .word_q(word_q)
  );

  assign cfg_rdata = word_q;

  srte_xact_fsm #(.SPLIT_W(SPLIT_W), .IVL_W(IVL_W), .LIM_W(LIM_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset), .cyc_tick(cyc_tick),
    .xact_start(xact_start), .tx_done(tx_done), .ack_valid(ack_valid),
    .ack_code(ack_code), .rsp_rcvd(rsp_rcvd),
    .split_to(word_q[TO_LO +: SPLIT_W]),
    .retry_ivl(word_q[IVL_LO +: IVL_W]),
    .retry_lim(word_q[LIM_LO +: LIM_W]),
    .retx_req(retx_req), .xact_ok(xact_ok), .xact_fail(xact_fail),
    .fail_code(fail_code)
  );

  srte_fetch_delay #(.FD_W(FD_W)) u_fetch (
    .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset), .cyc_tick(cyc_tick),
    .fetch_req(fetch_req), .delay(word_q[FD_LO +: FD_W]), .fetch_go(fetch_go)
  );
endmodule

// File: tb/srte_engine_bench.sv
`timescale 1ns/1ps
module srte_engine_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_reset = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        cyc_tick = 1'b0;
  logic        xact_start = 1'b0;
  logic        tx_done = 1'b0;
  logic        ack_valid = 1'b0;
  logic [3:0]  ack_code = '0;
  logic        rsp_rcvd = 1'b0;
  logic        fetch_req = 1'b0;
  logic        retx_req, fetch_go, xact_ok, xact_fail;
  logic [1:0]  fail_code;

  int tests = 0;
  int fails = 0;
  int n_retx = 0, n_ok = 0, n_fail = 0, n_go = 0;
  int b_retx, b_ok, b_fail, b_go;
  logic [1:0] last_fc = '0;

  always #2.5 clk = ~clk;

  srte_engine u_srte_engine (
    .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .cyc_tick(cyc_tick),
    .xact_start(xact_start), .tx_done(tx_done), .ack_valid(ack_valid),
    .ack_code(ack_code), .rsp_rcvd(rsp_rcvd), .fetch_req(fetch_req),
    .retx_req(retx_req), .fetch_go(fetch_go), .xact_ok(xact_ok),
    .xact_fail(xact_fail), .fail_code(fail_code)
  );

  // output monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (retx_req)  n_retx++;
    if (xact_ok)   n_ok++;
    if (xact_fail) begin n_fail++; last_fc = fail_code; end
    if (fetch_go)  n_go++;
  end

  task automatic check(input string req, input longint act, input longint exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic snap(); b_retx = n_retx; b_ok = n_ok; b_fail = n_fail; b_go = n_go; endtask
  task automatic idle(input int n); repeat (n) @(negedge clk); endtask
  task automatic p_tick();  @(negedge clk); cyc_tick = 1;   @(negedge clk); cyc_tick = 0;   endtask
  task automatic p_start(); @(negedge clk); xact_start = 1; @(negedge clk); xact_start = 0; endtask
  task automatic p_txd();   @(negedge clk); tx_done = 1;    @(negedge clk); tx_done = 0;    endtask
  task automatic p_rsp();   @(negedge clk); rsp_rcvd = 1;   @(negedge clk); rsp_rcvd = 0;   endtask
  task automatic p_fetch(); @(negedge clk); fetch_req = 1;  @(negedge clk); fetch_req = 0;  endtask
  task automatic p_breset(); @(negedge clk); bus_reset = 1; @(negedge clk); bus_reset = 0; endtask
  task automatic p_ack(input logic [3:0] c);
    @(negedge clk); ack_valid = 1; ack_code = c; @(negedge clk); ack_valid = 0; ack_code = 0;
  endtask
  task automatic cfg_write(input logic [31:0] d);
    @(negedge clk); cfg_we = 1; cfg_wdata = d; @(negedge clk); cfg_we = 0;
  endtask

  function automatic logic [31:0] mk_word(int to, int ivl, int lim, int fd);
    return {16'(to), 8'(ivl), 4'(lim), 4'(fd)};
  endfunction
  function automatic int exp_retx(int k, int lim); return (k > lim) ? lim : k; endfunction
  function automatic int exp_busy_fail(int k, int lim); return (k > lim) ? 1 : 0; endfunction
  function automatic int exp_to_fail(int n, int to); return (n > to) ? 1 : 0; endfunction

  // k busy acks, then a complete ack if retries remain
  task automatic busy_seq(input int ivl, input int lim, input int k, input string tag);
    cfg_write(mk_word(100, ivl, lim, 0));
    snap();
    p_start(); p_txd();
    for (int i = 0; i < k; i++) begin
      p_ack(4'(4 + (i % 3)));
      if (i < lim) begin repeat (ivl) p_tick(); idle(3); end
      else break;
    end
    if (k <= lim) p_ack(4'h1);
    idle(3);
    check({tag, " retx count"}, n_retx - b_retx, exp_retx(k, lim));
    check({tag, " fail"}, n_fail - b_fail, exp_busy_fail(k, lim));
    check({tag, " ok"}, n_ok - b_ok, 1 - exp_busy_fail(k, lim));
    if (exp_busy_fail(k, lim) == 1) check({tag, " code"}, last_fc, 2);
  endtask

  task automatic timeout_seq(input int to, input int n, input string tag);
    cfg_write(mk_word(to, 8, 14, 0));
    snap();
    p_start(); p_txd();
    repeat (n) p_tick();
    idle(3);
    check({tag, " fail"}, n_fail - b_fail, exp_to_fail(n, to));
    if (exp_to_fail(n, to) == 1) check({tag, " code"}, last_fc, 1);
    else begin
      p_rsp(); idle(2);
      check({tag, " ok after rsp"}, n_ok - b_ok, 1);
    end
  endtask

  task automatic fetch_seq(input int d, input string tag);
    cfg_write(mk_word(100, 8, 14, d));
    snap();
    p_fetch();
    if (d > 0) begin
      repeat (d - 1) p_tick();
      idle(3);
      check({tag, " no go early"}, n_go - b_go, 0);
      p_tick();
    end
    idle(3);
    check({tag, " go"}, n_go - b_go, 1);
  endtask

  initial begin : watchdog
    #1000000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd20240);
    idle(3);
    // R1 reset state
    check("R1 reset word", cfg_rdata, 32'h0320_08E0);
    check("R1 reset pulses", {retx_req, fetch_go, xact_ok, xact_fail}, 0);
    check("R1 reset code", fail_code, 0);
    rst_n = 1;
    idle(2);
    cfg_write(32'hA5A5_1234);
    idle(1);
    check("R1 write readback", cfg_rdata, 32'hA5A5_1234);

    // R3 complete and pending/response
    cfg_write(mk_word(50, 2, 2, 0));
    snap(); p_start(); p_txd(); p_ack(4'h1); idle(2);
    check("R3 complete ok", n_ok - b_ok, 1);
    snap(); p_start(); p_txd(); p_ack(4'h2); p_tick(); idle(3);
    check("R3 pending waits", n_ok - b_ok, 0);
    p_rsp(); idle(2);
    check("R3 response ok", n_ok - b_ok, 1);
    check("R11 no fail", n_fail - b_fail, 0);

    // R8 error acknowledge
    snap(); p_start(); p_txd(); p_ack(4'hD); idle(2);
    check("R8 ack error fail", n_fail - b_fail, 1);
    check("R8 ack error code", last_fc, 3);

    // R4 boundary
    timeout_seq(3, 3, "R4 at limit");
    timeout_seq(3, 4, "R4 above limit");
    timeout_seq(0, 1, "R4 zero limit");

    // R5 interval timing
    cfg_write(mk_word(100, 3, 2, 0));
    snap(); p_start(); p_txd(); p_ack(4'h5);
    p_tick(); p_tick(); idle(3);
    check("R5 no retx before interval", n_retx - b_retx, 0);
    p_tick(); idle(3);
    check("R5 retx after interval", n_retx - b_retx, 1);
    p_ack(4'h1); idle(2);
    check("R7 non-busy ends retries", n_ok - b_ok, 1);
    busy_seq(0, 1, 1, "R5 zero interval");

    // R6 limit zero
    busy_seq(2, 0, 1, "R6 limit zero");
    // R7 exhaustion with the reset-value limit of 14
    busy_seq(0, 14, 15, "R7 limit fourteen");
    busy_seq(1, 3, 4, "R7 exhausted");

    // R10 start ignored and fields captured
    cfg_write(mk_word(100, 1, 2, 0));
    snap(); p_start(); p_txd(); p_ack(4'h4);
    p_start();
    cfg_write(mk_word(100, 9, 0, 0));
    p_tick(); idle(3);
    check("R10 captured interval", n_retx - b_retx, 1);
    p_ack(4'h4); p_tick(); idle(3);
    check("R10 captured limit", n_retx - b_retx, 2);
    p_ack(4'h1); idle(2);
    check("R10 single ok", n_ok - b_ok, 1);
    check("R10 no fail", n_fail - b_fail, 0);

    // R9 fetch delay
    fetch_seq(3, "R9 delay three");
    fetch_seq(0, "R9 delay zero");

    // R2 bus reset
    cfg_write(mk_word(0, 1, 1, 2));
    snap(); p_start(); p_txd(); p_fetch(); p_breset();
    check("R2 word kept", cfg_rdata, mk_word(0, 1, 1, 2));
    repeat (4) p_tick(); idle(3);
    check("R2 no fail after abort", n_fail - b_fail, 0);
    check("R2 no go after abort", n_go - b_go, 0);
    check("R2 no ok after abort", n_ok - b_ok, 0);
    p_start(); p_txd(); p_tick(); idle(3);
    check("R2 engine usable again", n_fail - b_fail, 1);

    // constrained random mix
    for (int it = 0; it < 30; it++) begin
      int kind;
      kind = int'($urandom_range(0, 2));
      if (kind == 0) busy_seq(int'($urandom_range(0, 3)), int'($urandom_range(0, 3)),
                              int'($urandom_range(0, 5)), "R7 random busy");
      else if (kind == 1) timeout_seq(int'($urandom_range(0, 5)), int'($urandom_range(0, 7)),
                                      "R4 random timeout");
      else fetch_seq(int'($urandom_range(0, 5)), "R9 random fetch");
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule